// File: doc/BRIEF.md
# Palette DAC Port Sequencer

This block is the processor-side front end of a colour lookup table with 2^IDX_W entries, 256 by default. Each entry holds a red, a green and a blue component of COMP_W bits. Software talks to it over an 8-bit I/O bus through four byte offsets:

- a pixel mask;
- a read index, which reads back as mode status;
- a write index;
- one shared data port.

The data port carries the three components of an entry in a fixed red, green, blue sequence. A phase counter inside the block tracks which component comes next.

On the display side, every clock a pixel index arrives. It is ANDed with the mask, and the masked value addresses a second read port of the table. The table is one simple dual-port memory that block RAM can hold. Red and green writes are kept in staging registers, and the whole entry is written in one memory write when blue arrives. A partly written entry therefore never shows on the pixel path.

Bus reads return data one clock after the read strobe. A read of the data port must come at least two clocks after the last change of the read index and after the last entry commit, so that the memory has had time to refetch the entry.

Top module: `pal_port_top`

## Requirements
- R1: After reset the mask reads 0xFF, the status reads 0x00 (write mode) and the write index reads 0x00.
- R2: A write to offset 0x8 loads the write index and restarts the component phase at red. Reading offset 0x8 returns the current write index.
- R3: Three successive writes to offset 0x9 supply red, green and blue, in that order, for the entry at the write index. Only the low COMP_W bits of each write are kept, and the bits above them are ignored.
- R4: An entry changes only on the third (blue) data write. If the write index is reloaded after one or two data writes, the entry keeps its old contents.
- R5: After each blue write the write index steps by one, wrapping from the last entry to 0, and the phase returns to red.
- R6: A write to offset 0x7 loads the read index and restarts the read phase. Successive reads of offset 0x9 return red, green, then blue of that entry, zero-extended. After blue the read index steps by one and wraps.
- R7: A read of offset 0x7 returns 0x03 when the last index write went to the read index, and 0x00 when it went to the write index.
- R8: One clock after a pixel index is presented, the RGB outputs show the entry addressed by the pixel index ANDed with the mask.
- R9: A write to offset 0x6 loads the mask, and a read of offset 0x6 returns it.
- R10: Bus read data appears one clock after the read strobe. Offsets other than 0x6 to 0x9 read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Bus write strobe, one clock per access |
| io_rd | input | 1 | Bus read strobe, one clock per access |
| io_addr | input | 4 | Byte offset within the port window |
| io_wdata | input | 8 | Bus write data |
| io_rdata | output | 8 | Registered bus read data |
| pix_idx | input | IDX_W | Pixel colour index |
| rgb_r | output | COMP_W | Red component of the looked-up entry |
| rgb_g | output | COMP_W | Green component of the looked-up entry |
| rgb_b | output | COMP_W | Blue component of the looked-up entry |

## Verification
The bench builds the block with its default parameters, IDX_W = 8 and COMP_W = 6. It loads all 256 entries through the auto-incrementing write index and sweeps every pixel index, first with the full mask and then with a four-bit mask. This brings within reach the wrap of the write index at 255, the wrap of the read index during a readback that runs across the top of the table, the discarding of a partial triplet, and the removal of the upper data bits.

// File: rtl/pal_pkg.sv
package pal_pkg;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_t;

  localparam logic [3:0] OFS_MASK = 4'h6;
  localparam logic [3:0] OFS_RIDX = 4'h7;
  localparam logic [3:0] OFS_WIDX = 4'h8;
  localparam logic [3:0] OFS_DATA = 4'h9;

  localparam logic [7:0] STAT_READ  = 8'h03;
  localparam logic [7:0] STAT_WRITE = 8'h00;

endpackage

// File: rtl/pal_ram.sv
module pal_ram #(
  parameter int IDX_W = 8,
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             we_a,
  input  logic [IDX_W-1:0] addr_a,
  input  logic [WIDTH-1:0] wdata_a,
  output logic [WIDTH-1:0] q_a,
  input  logic [IDX_W-1:0] addr_b,
  output logic [WIDTH-1:0] q_b
);
  localparam int DEPTH = 1 << IDX_W;

  logic [WIDTH-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we_a) mem[addr_a] <= wdata_a;
    q_a <= mem[addr_a];
  end

  always_ff @(posedge clk) begin
    q_b <= mem[addr_b];
  end

endmodule

// File: rtl/pal_cpu_port.sv
module pal_cpu_port
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6,
  parameter int DW     = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                io_wr,
  input  logic                io_rd,
  input  logic [3:0]          io_addr,
  input  logic [DW-1:0]       io_wdata,
  output logic                ram_we,
  output logic [IDX_W-1:0]    ram_addr,
  output logic [3*COMP_W-1:0] ram_wdata,
  output logic [IDX_W-1:0]    mask_q,
  output logic [IDX_W-1:0]    wr_idx,
  output logic [IDX_W-1:0]    rd_idx,
  output phase_t              wr_phase,
  output phase_t              rd_phase,
  output logic                rd_mode
);
  logic              wr_mask, wr_ridx, wr_widx, wr_data, rd_data;
  logic [COMP_W-1:0] stage_r, stage_g, comp_in;

  assign wr_mask = io_wr && (io_addr == OFS_MASK);
  assign wr_ridx = io_wr && (io_addr == OFS_RIDX);
  assign wr_widx = io_wr && (io_addr == OFS_WIDX);
  assign wr_data = io_wr && (io_addr == OFS_DATA);
  assign rd_data = io_rd && (io_addr == OFS_DATA);
  assign comp_in = io_wdata[COMP_W-1:0];

  // the whole entry is written once, on the blue write
  assign ram_we    = wr_data && (wr_phase == PH_BLU);
  assign ram_wdata = {stage_r, stage_g, comp_in};
  assign ram_addr  = ram_we ? wr_idx : rd_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '1;
      wr_idx   <= '0;
      rd_idx   <= '0;
      wr_phase <= PH_RED;
      rd_phase <= PH_RED;
      rd_mode  <= 1'b0;
      stage_r  <= '0;
      stage_g  <= '0;
    end else begin
      if (wr_mask) mask_q <= io_wdata[IDX_W-1:0];
      if (wr_ridx) begin
        rd_idx   <= io_wdata[IDX_W-1:0];
        rd_phase <= PH_RED;
        rd_mode  <= 1'b1;
      end
      if (wr_widx) begin
        wr_idx   <= io_wdata[IDX_W-1:0];
        wr_phase <= PH_RED;
        rd_mode  <= 1'b0;
      end
      if (wr_data) begin
        unique case (wr_phase)
          PH_RED: begin
            stage_r  <= comp_in;
            wr_phase <= PH_GRN;
          end
          PH_GRN: begin
            stage_g  <= comp_in;
            wr_phase <= PH_BLU;
          end
          default: begin
            wr_phase <= PH_RED;
            wr_idx   <= wr_idx + 1'b1;
          end
        endcase
      end
      if (rd_data) begin
        unique case (rd_phase)
          PH_RED:  rd_phase <= PH_GRN;
          PH_GRN:  rd_phase <= PH_BLU;
          default: begin
            rd_phase <= PH_RED;
            rd_idx   <= rd_idx + 1'b1;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/pal_rd_mux.sv
module pal_rd_mux
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6,
  parameter int DW     = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                io_rd,
  input  logic [3:0]          io_addr,
  input  logic [IDX_W-1:0]    mask_q,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic                rd_mode,
  input  phase_t              rd_phase,
  input  logic [3*COMP_W-1:0] entry_q,
  output logic [DW-1:0]       io_rdata
);
  logic [COMP_W-1:0] comp_sel;

  always_comb begin
    unique case (rd_phase)
      PH_RED:  comp_sel = entry_q[3*COMP_W-1:2*COMP_W];
      PH_GRN:  comp_sel = entry_q[2*COMP_W-1:COMP_W];
      default: comp_sel = entry_q[COMP_W-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata <= '0;
    end else if (io_rd) begin
      unique case (io_addr)
        OFS_MASK: io_rdata <= DW'(mask_q);
        OFS_RIDX: io_rdata <= rd_mode ? DW'(STAT_READ) : DW'(STAT_WRITE);
        OFS_WIDX: io_rdata <= DW'(wr_idx);
        OFS_DATA: io_rdata <= DW'(comp_sel);
        default:  io_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/pal_port_top.sv
module pal_port_top
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [3:0]        io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic [COMP_W-1:0] rgb_r,
  output logic [COMP_W-1:0] rgb_g,
  output logic [COMP_W-1:0] rgb_b
);
  localparam int DW    = 8;
  localparam int ENT_W = 3 * COMP_W;

  logic             ram_we;
  logic [IDX_W-1:0] ram_addr, mask_q, wr_idx, rd_idx, pix_addr;
  logic [ENT_W-1:0] ram_wdata, entry_q, pix_q;
  phase_t           wr_phase, rd_phase;
  logic             rd_mode;

  pal_cpu_port #(.IDX_W(IDX_W), .COMP_W(COMP_W), .DW(DW)) port_i (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd),
    .io_addr(io_addr), .io_wdata(io_wdata),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .mask_q(mask_q), .wr_idx(wr_idx), .rd_idx(rd_idx),
    .wr_phase(wr_phase), .rd_phase(rd_phase), .rd_mode(rd_mode)
  );

  assign pix_addr = pix_idx & mask_q;

  pal_ram #(.IDX_W(IDX_W), .WIDTH(ENT_W)) ram_i (
    .clk(clk), .we_a(ram_we), .addr_a(ram_addr), .wdata_a(ram_wdata),
    .q_a(entry_q), .addr_b(pix_addr), .q_b(pix_q)
  );

  pal_rd_mux #(.IDX_W(IDX_W), .COMP_W(COMP_W), .DW(DW)) mux_i (
    .clk(clk), .rst(rst), .io_rd(io_rd), .io_addr(io_addr),
    .mask_q(mask_q), .wr_idx(wr_idx), .rd_mode(rd_mode),
    .rd_phase(rd_phase), .entry_q(entry_q), .io_rdata(io_rdata)
  );

  assign rgb_r = pix_q[ENT_W-1:2*COMP_W];
  assign rgb_g = pix_q[2*COMP_W-1:COMP_W];
  assign rgb_b = pix_q[COMP_W-1:0];

endmodule

// File: rtl/pal_port_chk.sv
module pal_port_chk
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             io_wr,
  input logic             io_rd,
  input logic [3:0]       io_addr,
  input logic [7:0]       io_wdata,
  input logic             ram_we,
  input logic [IDX_W-1:0] wr_idx,
  input logic [IDX_W-1:0] rd_idx,
  input logic [IDX_W-1:0] mask_q,
  input phase_t           wr_phase,
  input phase_t           rd_phase,
  input logic             rd_mode
);
  logic [1:0] dcnt;

  always_ff @(posedge clk) begin
    if (rst) dcnt <= 2'd0;
    else if (io_wr && io_addr == OFS_WIDX) dcnt <= 2'd0;
    else if (io_wr && io_addr == OFS_DATA) dcnt <= (dcnt == 2'd2) ? 2'd0 : dcnt + 2'd1;
  end

  // R4
  commit_after_three_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> dcnt == 2'd2);

  // R5
  widx_step_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> (wr_idx == IDX_W'($past(wr_idx) + 1'b1)) && (wr_phase == PH_RED));

  // R2
  widx_load_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == OFS_WIDX) |=>
      (wr_idx == $past(io_wdata[IDX_W-1:0])) && (wr_phase == PH_RED) && !rd_mode);

  // R7
  ridx_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == OFS_RIDX) |=>
      rd_mode && (rd_idx == $past(io_wdata[IDX_W-1:0])) && (rd_phase == PH_RED));

  // R6
  ridx_step_chk: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !io_wr && io_addr == OFS_DATA && rd_phase == PH_BLU) |=>
      (rd_idx == IDX_W'($past(rd_idx) + 1'b1)) && (rd_phase == PH_RED));

  // R9
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == OFS_MASK) |=> mask_q == $past(io_wdata[IDX_W-1:0]));

endmodule

bind pal_port_top pal_port_chk #(.IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
  .io_wdata(io_wdata), .ram_we(ram_we), .wr_idx(wr_idx), .rd_idx(rd_idx),
  .mask_q(mask_q), .wr_phase(wr_phase), .rd_phase(rd_phase), .rd_mode(rd_mode)
);

// File: tb/pal_port_top_tb_top.sv
module pal_port_top_tb_top;
  localparam int IDX_W  = 8;
  localparam int COMP_W = 6;
  localparam int DEPTH  = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              io_wr = 1'b0, io_rd = 1'b0;
  logic [3:0]        io_addr = '0;
  logic [7:0]        io_wdata = '0;
  logic [7:0]        io_rdata;
  logic [IDX_W-1:0]  pix_idx = '0;
  logic [COMP_W-1:0] rgb_r, rgb_g, rgb_b;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  int er [DEPTH];
  int eg [DEPTH];
  int eb [DEPTH];

  always #4 clk = ~clk;

  pal_port_top #(.IDX_W(IDX_W), .COMP_W(COMP_W)) dut_i (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .pix_idx(pix_idx),
    .rgb_r(rgb_r), .rgb_g(rgb_g), .rgb_b(rgb_b)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    io_rd = 1'b1; io_addr = a;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
    @(negedge clk);
  endtask

  task automatic pix_chk(input string req, input int p, input int mask);
    int e;
    @(negedge clk);
    pix_idx = IDX_W'(p);
    @(negedge clk);
    e = p & mask;
    check(req, {rgb_r, rgb_g, rgb_b},
          {er[e][COMP_W-1:0], eg[e][COMP_W-1:0], eb[e][COMP_W-1:0]});
  endtask

  initial begin
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    bus_rd(4'h6, d); check("R1 mask reset", d, 8'hFF);
    bus_rd(4'h7, d); check("R1 status reset", d, 8'h00);
    bus_rd(4'h8, d); check("R1 widx reset", d, 8'h00);
    bus_rd(4'h0, d); check("R10 unmapped 0x0", d, 0);
    bus_rd(4'hA, d); check("R10 unmapped 0xA", d, 0);

    bus_wr(4'h8, 8'h00);
    bus_rd(4'h8, d); check("R2 widx load", d, 0);
    for (int i = 0; i < DEPTH; i++) begin
      er[i] = (i * 7 + 1) & 63;
      eg[i] = ((i * 3) ^ 21) & 63;
      eb[i] = (255 - i) & 63;
      bus_wr(4'h9, 8'(((i & 3) << 6) | er[i]));
      bus_wr(4'h9, 8'(((i & 1) << 7) | eg[i]));
      bus_wr(4'h9, 8'(((i & 2) << 5) | eb[i]));
      if (i == 0) begin
        bus_rd(4'h8, d); check("R5 widx step", d, 1);
      end
    end
    bus_rd(4'h8, d); check("R5 widx wrap", d, 0);

    for (int p = 0; p < DEPTH; p++) pix_chk("R3 R8 full mask", p, 8'hFF);

    bus_wr(4'h6, 8'h0F);
    bus_rd(4'h6, d); check("R9 mask readback", d, 8'h0F);
    for (int p = 0; p < DEPTH; p++) pix_chk("R8 masked lookup", p, 8'h0F);
    bus_wr(4'h6, 8'hFF);

    bus_wr(4'h8, 8'd10);
    bus_wr(4'h9, 8'h3F);
    bus_wr(4'h9, 8'h3F);
    bus_wr(4'h8, 8'd20);
    bus_rd(4'h8, d); check("R2 widx reload", d, 20);
    pix_chk("R4 partial discarded", 10, 8'hFF);
    bus_wr(4'h9, 8'hD1);
    bus_wr(4'h9, 8'h22);
    pix_chk("R4 no commit before blue", 20, 8'hFF);
    bus_wr(4'h9, 8'h73);
    er[20] = 8'h11; eg[20] = 8'h22; eb[20] = 8'h33;
    pix_chk("R3 restart triplet", 20, 8'hFF);

    bus_wr(4'h7, 8'd254);
    bus_rd(4'h7, d); check("R7 read mode", d, 8'h03);
    for (int k = 0; k < 4; k++) begin
      int e;
      e = (254 + k) % DEPTH;
      bus_rd(4'h9, d); check("R6 readback red", d, er[e]);
      bus_rd(4'h9, d); check("R6 readback green", d, eg[e]);
      bus_rd(4'h9, d); check("R6 readback blue", d, eb[e]);
    end
    bus_wr(4'h7, 8'd20);
    bus_rd(4'h9, d); check("R6 readback updated red", d, 8'h11);
    bus_rd(4'h9, d); check("R6 readback updated green", d, 8'h22);
    bus_wr(4'h8, 8'd5);
    bus_rd(4'h7, d); check("R7 write mode", d, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule